// File: doc/BRIEF.md
# Pipelined Natural-Logarithm Unit (Hyperbolic CORDIC)

This block turns a positive unsigned magnitude, such as a detected power or envelope sample, into its natural logarithm in signed fixed point. The loop of a log-domain gain controller uses that result as its error term. The block has no lookup table. A priority encoder first splits the input into a mantissa `w` in [0.5, 1) and an exponent `e`, so that `input = w * 2^e`. A chain of hyperbolic CORDIC micro-rotations in vectoring mode then evaluates `ln(w)`. The rotations start from `x = w + 1`, `y = w - 1` and `z = 0`, and the result is `ln(w) = 2*z` once `y` has been driven to zero. The last stage adds `e * ln2` to this value.

Each micro-rotation is a separate register stage, and each stage does only shifts, adds and subtractions. The unit therefore takes one sample per clock and returns results at the same rate after a fixed delay. The number of distinct shift values `ITER` is a parameter. The shifts 4 and 13 are each applied twice so that the hyperbolic series converges. Each additional iteration adds roughly one bit of accuracy, at the cost of one more stage. A zero input has no logarithm. For a zero input the block raises a flag and returns the most negative output code.

Top module: `hcordic_ln`

## Requirements
- R1: While `rst` is high, and on the first sampling after it, `out_valid` and `out_invalid` are 0.
- R2: Each accepted sample (`in_valid` high at a rising edge) gives exactly one `out_valid` pulse, in input order. The pulse follows exactly `N_ST+1` rising edges after the capturing edge, where `N_ST = ITER + (ITER>=4) + (ITER>=13)`. Back-to-back samples give back-to-back results.
- R3: For a nonzero input `v`, `out_ln` read as a two's-complement number with `FRAC` fractional bits is within `2^(3-ITER) + (N_ST + 2*IN_W) * 2^-FRAC` of ln(v).
- R4: For an input of zero, the result carries `out_invalid = 1` and `out_ln` equals the most negative code, `-2^(OUT_W-1)`.
- R5: Exact powers of two from 2^0 to 2^(IN_W-1), including the input 1 (result near 0), meet the accuracy bound of R3. This shows that the exponent-times-ln2 path is exact.
- R6: `out_invalid` is high only in a cycle where `out_valid` is high, and it is 0 for every nonzero input.
- R7: While `out_valid` is low, `out_ln` keeps the value of the last result delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_data` as a sample to convert |
| in_data | input | IN_W | Unsigned input magnitude |
| out_valid | output | 1 | Marks a result on `out_ln` |
| out_ln | output | OUT_W | Signed natural log, FRAC fractional bits |
| out_invalid | output | 1 | Result came from a zero input |

## Verification
The bound checker tests several properties on every clock. It tests the fixed valid latency against a shadow shift register. It tests that the invalid flag only appears together with a valid result. It tests that a zero result carries the minimum code, and that the output holds its value between results. Numerical accuracy can only be shown by the bench's scenarios. The bench compares each result with a real-valued logarithm across powers of two, the extremes of the range, small integers and pseudo-random magnitudes. Back-to-back streams, gaps and zero inputs mixed into the traffic show that results stay in order and are paired with the right inputs.

// File: rtl/log_pkg.sv
package log_pkg;

  // Number of pipelined micro-rotations for a given count of distinct shifts
  function automatic int num_stages(input int iter);
    return iter + ((iter >= 4) ? 1 : 0) + ((iter >= 13) ? 1 : 0) + ((iter >= 40) ? 1 : 0);
  endfunction

  // Shift amount used by stage s; shifts 4, 13 and 40 are applied twice
  function automatic int shift_at(input int s);
    int i;
    bit again;
    i = 1;
    again = 1'b0;
    for (int k = 0; k < s; k++) begin
      if ((i == 4 || i == 13 || i == 40) && !again) again = 1'b1;
      else begin
        again = 1'b0;
        i++;
      end
    end
    return i;
  endfunction

  // atanh(2^-i) scaled by 2^frac, from the odd power series at 2^-60 precision
  function automatic logic [63:0] atanh_fix(input int i, input int frac);
    logic [63:0] acc;
    acc = '0;
    for (int k = 1; k < 64; k += 2)
      if (k * i <= 60) acc += (64'd1 << (60 - k * i)) / 64'(k);
    return (acc + (64'd1 << (59 - frac))) >> (60 - frac);
  endfunction

  // ln(2) = sum 1/(k*2^k), scaled by 2^frac
  function automatic logic [63:0] ln2_fix(input int frac);
    logic [63:0] acc;
    acc = '0;
    for (int k = 1; k <= 60; k++)
      acc += (64'd1 << (60 - k)) / 64'(k);
    return (acc + (64'd1 << (59 - frac))) >> (60 - frac);
  endfunction

endpackage

// File: rtl/hcl_norm.sv
module hcl_norm #(
  parameter int IN_W = 16,
  parameter int FRAC = 20,
  parameter int EW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            v_i,
  input  logic [IN_W-1:0] d_i,
  output logic            v_o,
  output logic            zero_o,
  output logic [EW-1:0]   e_o,
  output logic [FRAC:0]   w_o
);
  localparam int TW = FRAC + 1;

  logic [EW-1:0] e_c;
  logic [TW-1:0] w_c;

  // Leading-one search: exponent = msb position + 1
  always_comb begin
    e_c = '0;
    for (int b = 0; b < IN_W; b++)
      if (d_i[b]) e_c = EW'(b + 1);
    w_c = TW'(d_i) << (FRAC - int'(e_c));
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
    if (v_i) begin
      zero_o <= (d_i == '0);
      e_o    <= e_c;
      w_o    <= w_c;
    end
  end
endmodule

// File: rtl/hcl_stage.sv
module hcl_stage #(
  parameter int          DW  = 23,
  parameter int          ZW  = 22,
  parameter int          EW  = 5,
  parameter int          SH  = 1,
  parameter logic [ZW-1:0] ANG = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_i,
  input  logic                 zero_i,
  input  logic [EW-1:0]        e_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  output logic                 v_o,
  output logic                 zero_o,
  output logic [EW-1:0]        e_o,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);
  logic signed [DW-1:0] xn, yn;
  logic signed [ZW-1:0] zn;

  // x stays positive, so direction depends only on the sign of y
  always_comb begin
    if (y_i[DW-1]) begin
      xn = x_i + (y_i >>> SH);
      yn = y_i + (x_i >>> SH);
      zn = z_i - $signed(ANG);
    end else begin
      xn = x_i - (y_i >>> SH);
      yn = y_i - (x_i >>> SH);
      zn = z_i + $signed(ANG);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
    if (v_i) begin
      zero_o <= zero_i;
      e_o    <= e_i;
      x_o    <= xn;
      y_o    <= yn;
      z_o    <= zn;
    end
  end
endmodule

// File: rtl/hcordic_ln.sv
module hcordic_ln #(
  parameter int IN_W = 16,
  parameter int FRAC = 20,
  parameter int ITER = 16,
  parameter int OUT_W = FRAC + $clog2(IN_W) + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [IN_W-1:0]         in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_ln,
  output logic                    out_invalid
);
  import log_pkg::*;

  localparam int N_ST = num_stages(ITER);
  localparam int LAT  = N_ST + 1;
  localparam int EW   = $clog2(IN_W + 1);
  localparam int DW   = FRAC + 3;
  localparam int ZW   = FRAC + 2;
  localparam logic signed [OUT_W-1:0] LN2_C  = OUT_W'(ln2_fix(FRAC));
  localparam logic signed [OUT_W-1:0] MIN_C  = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic signed [DW-1:0]    ONE_C  = DW'(64'd1 << FRAC);

  logic                 n_v, n_zero;
  logic [EW-1:0]        n_e;
  logic [FRAC:0]        n_w;

  hcl_norm #(.IN_W(IN_W), .FRAC(FRAC), .EW(EW)) u_norm (
    .clk(clk), .rst(rst), .v_i(in_valid), .d_i(in_data),
    .v_o(n_v), .zero_o(n_zero), .e_o(n_e), .w_o(n_w)
  );

  logic                 sv [0:N_ST];
  logic                 sz [0:N_ST];
  logic [EW-1:0]        se [0:N_ST];
  logic signed [DW-1:0] sx [0:N_ST];
  logic signed [DW-1:0] sy [0:N_ST];
  logic signed [ZW-1:0] szz[0:N_ST];

  assign sv[0]  = n_v;
  assign sz[0]  = n_zero;
  assign se[0]  = n_e;
  assign sx[0]  = $signed(DW'(n_w)) + ONE_C;
  assign sy[0]  = $signed(DW'(n_w)) - ONE_C;
  assign szz[0] = '0;

  for (genvar s = 0; s < N_ST; s++) begin : g_rot
    localparam int SH_S = shift_at(s);
    hcl_stage #(
      .DW(DW), .ZW(ZW), .EW(EW), .SH(SH_S),
      .ANG(ZW'(atanh_fix(SH_S, FRAC)))
    ) u_rot (
      .clk(clk), .rst(rst),
      .v_i(sv[s]), .zero_i(sz[s]), .e_i(se[s]),
      .x_i(sx[s]), .y_i(sy[s]), .z_i(szz[s]),
      .v_o(sv[s+1]), .zero_o(sz[s+1]), .e_o(se[s+1]),
      .x_o(sx[s+1]), .y_o(sy[s+1]), .z_o(szz[s+1])
    );
  end

  logic signed [OUT_W-1:0] sum_c;
  always_comb begin
    sum_c = OUT_W'(szz[N_ST]) * 2 + $signed(OUT_W'(se[N_ST])) * LN2_C;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_invalid <= 1'b0;
      out_ln      <= '0;
    end else begin
      out_valid   <= sv[N_ST];
      out_invalid <= sv[N_ST] & sz[N_ST];
      if (sv[N_ST]) out_ln <= sz[N_ST] ? MIN_C : sum_c;
    end
  end
endmodule

// File: rtl/hcl_chk.sv
module hcl_chk #(
  parameter int LAT   = 19,
  parameter int OUT_W = 26
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_ln,
  input logic                    out_invalid
);
  logic [LAT:0] vp;
  always_ff @(posedge clk) begin
    if (rst) vp <= '0;
    else     vp <= {vp[LAT-1:0], in_valid};
  end

  // R2
  latency_match_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == vp[LAT]);

  // R6
  invalid_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> out_valid);

  // R4
  zero_min_code_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_invalid) |-> (out_ln == {1'b1, {(OUT_W-1){1'b0}}}));

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_ln));
endmodule

bind hcordic_ln hcl_chk #(.LAT(LAT), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_ln(out_ln), .out_invalid(out_invalid)
);

// File: tb/sim_hcordic_ln.sv
`timescale 1ns/1ps
module sim_hcordic_ln;
  localparam int IN_W  = 16;
  localparam int FRAC  = 20;
  localparam int ITER  = 16;
  localparam int OUT_W = FRAC + $clog2(IN_W) + 2;
  localparam int NST   = ITER + ((ITER >= 4) ? 1 : 0) + ((ITER >= 13) ? 1 : 0);
  localparam int DLY   = NST + 1;
  localparam real TOL  = 2.0 ** (3 - ITER) + real'(NST + 2 * IN_W) * 2.0 ** (-FRAC);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [IN_W-1:0] in_data = '0;
  logic out_valid, out_invalid;
  logic signed [OUT_W-1:0] out_ln;

  always #2.5 clk = ~clk;

  hcordic_ln #(.IN_W(IN_W), .FRAC(FRAC), .ITER(ITER)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_ln(out_ln), .out_invalid(out_invalid)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit seen = 1'b0;
  logic signed [OUT_W-1:0] last_ln;
  int unsigned q_val[$];
  int q_cyc[$];

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic send(input int unsigned v);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = IN_W'(v);
    q_val.push_back(v);
    q_cyc.push_back(cyc + 1);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = '0;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (q_val.size() == 0) begin
          check(1'b0, "R2", $sformatf("unexpected result got=%0d exp=none", out_ln));
        end else begin
          int unsigned v;
          int c0;
          v  = q_val.pop_front();
          c0 = q_cyc.pop_front();
          check(cyc - c0 == DLY, "R2",
                $sformatf("latency got=%0d exp=%0d", cyc - c0, DLY));
          if (v == 0) begin
            check(out_invalid == 1'b1, "R4",
                  $sformatf("flag got=%0b exp=1", out_invalid));
            check(out_ln == {1'b1, {(OUT_W-1){1'b0}}}, "R4",
                  $sformatf("code got=%0d exp=%0d", out_ln, -(2 ** (OUT_W - 1))));
          end else begin
            real got, exp_v;
            bit pow2;
            got   = real'(out_ln) / 2.0 ** FRAC;
            exp_v = $ln(real'(v));
            pow2  = ((v & (v - 1)) == 0);
            check(out_invalid == 1'b0, "R6",
                  $sformatf("flag for in=%0d got=%0b exp=0", v, out_invalid));
            check((got - exp_v <= TOL) && (exp_v - got <= TOL), pow2 ? "R5" : "R3",
                  $sformatf("in=%0d got=%f exp=%f", v, got, exp_v));
          end
          last_ln = out_ln;
          seen    = 1'b1;
        end
      end else begin
        check(out_invalid == 1'b0, "R6",
              $sformatf("flag while idle got=%0b exp=0", out_invalid));
        if (seen)
          check(out_ln == last_ln, "R7",
                $sformatf("idle output got=%0d exp=%0d", out_ln, last_ln));
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    check(1'b0, "WATCHDOG", "timeout got=running exp=finished");
    finish_run();
  end

  initial begin
    int unsigned lf;
    // R1: reset state
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(out_valid == 1'b0 && out_invalid == 1'b0, "R1",
            $sformatf("during reset got=%0b%0b exp=00", out_valid, out_invalid));
    end
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_invalid == 1'b0, "R1",
          $sformatf("after reset got=%0b%0b exp=00", out_valid, out_invalid));

    // R5: powers of two, back to back
    for (int k = 0; k < IN_W; k++) send(32'd1 << k);
    idle(3);
    // R3: small integers and the top of the range
    for (int v = 2; v < 40; v++) if ((v & (v - 1)) != 0) send(v);
    send(2 ** IN_W - 1);
    send(2 ** (IN_W - 1) + 1);
    idle(DLY + 4);
    // R4: zeros mixed with data, with gaps
    send(0);
    send(1000);
    idle(2);
    send(0);
    send(0);
    send(7);
    idle(DLY + 3);
    // R3 / R2: pseudo-random stream with occasional gaps
    lf = 32'h1234_5678;
    for (int k = 0; k < 300; k++) begin
      lf ^= lf << 13;
      lf ^= lf >> 17;
      lf ^= lf << 5;
      send(lf & ((1 << IN_W) - 1));
      if (lf[3:0] == 4'h0) idle(lf[6:4] + 1);
    end
    idle(DLY + 6);
    check(q_val.size() == 0, "R2",
          $sformatf("outstanding got=%0d exp=0", q_val.size()));
    finish_run();
  end
endmodule